// File: doc/BRIEF.md
# Rotating-Priority Eight-Line Interrupt Controller

This block collects interrupt requests from eight input lines, tracks which are pending, masked and in service, and raises a single interrupt output to a processor when the best pending, unmasked request outranks everything currently in service. Priority is circular: a three-bit base names the line that currently ranks highest, and rank falls off line by line from there, wrapping past line 7 to line 0. End-of-interrupt and rotate commands move the base so that a line just served drops to lowest rank.

Software reaches the block through a byte register port with a single address bit. Address 0 takes the start-up command, end-of-interrupt and rotate commands, and the read-select, poll and special-mask commands. Address 1 takes the start-up words that follow and, once start-up is done, the mask. Reads return the request, in-service or mask register, or the result of an armed poll. A processor acknowledge pulse hands over the winning line and its vector number one clock later. Per-line trigger type (edge or level) arrives as an input vector.

Top module: `rpic_top`

## Requirements
- R1: An edge-triggered line (trig_level_i bit 0) sets its request bit only when its input goes from 0 to 1 relative to the level seen on the previous clock; holding the input high after the bit is cleared does not set it again.
- R2: A level-triggered line (trig_level_i bit 1) has its request bit follow the input each clock, and acknowledge does not clear it.
- R3: A line whose mask bit is 1 never raises int_o; a write at address 1 in normal operation loads the mask and a read at address 1 returns it.
- R4: The winning request is the unmasked request line reached first when counting upward from the base, modulo 8; int_o is 1 only when that line ranks strictly above the highest-ranked in-service line.
- R5: When the fourth start-up word set bit 4 (nested cascade mode) and the block is configured as the master, in-service bit 2 is left out of the comparison of R4.
- R6: An acknowledge pulse with a winner sets its in-service bit (unless auto-EOI), clears its request bit if edge-triggered, and one clock later drives ack_valid_o=1 with ack_line_o=line and ack_vec_o={vector base bits 7:3, line}; with no winner ack_valid_o=0 and ack_line_o=7.
- R7: In auto-EOI mode (fourth start-up word bit 1) an acknowledge leaves the in-service register unchanged; when rotate-on-auto-EOI is on (address 0 command code 4 in bits 7:5, code 0 turns it off) the base becomes line+1.
- R8: An address-0 write with bit 4 set clears every register and deasserts int_o; bit 0 says whether a fourth word follows. The next address-1 writes load the vector base (bits 7:3), then the second word, then the optional fourth word; only after that does address 1 load the mask.
- R9: An address-0 write with bit 4 clear and bit 3 set, with bit 1 set, chooses what a read at address 0 returns: bit 0 = 1 the in-service register, 0 the request register.
- R10: Command code 1 (bits 7:5, bits 4:3 clear) clears the highest-ranked in-service bit; code 5 does so and sets the base to that line+1.
- R11: Code 3 clears the in-service bit of line bits 2:0; code 7 also sets the base to that line+1; code 6 sets the base to bits 2:0 plus 1.
- R12: After a command with bits 4:3 = 01 and bit 2 set arms a poll, the next read returns the winning line and clears its request and in-service bits, or returns 7 with no winner; the poll is then disarmed.
- R13: With special mask on (bits 4:3 = 01, bit 6 set, bit 5 = 1; bit 5 = 0 turns it off) masked in-service bits are left out of the comparison of R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 8 | Interrupt request lines |
| trig_level_i | input | 8 | Per-line trigger type, 1 = level, 0 = edge |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe |
| addr_i | input | 1 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid the clock after rd_i |
| ack_i | input | 1 | Processor acknowledge pulse |
| int_o | output | 1 | Interrupt request to processor |
| ack_valid_o | output | 1 | Acknowledge returned a real line |
| ack_line_o | output | 3 | Acknowledged line, 7 when spurious |
| ack_vec_o | output | 8 | Vector number of the acknowledged line |

## Verification
The assertions watch, on every clock, that a fully masked controller stays silent, that int_o never rises without an unmasked request, that ack_valid_o only follows an acknowledge, that auto-EOI acknowledges leave the in-service register alone, that a start-up command empties the registers, and that a poll read disarms the poll. Which line wins under each base and request pattern, how the base moves under the rotate commands, the start-up word order with three and four words, and the effect of nested cascade and special mask modes on the in-service comparison are shown only by the bench scenarios, including a sweep of all 255 request patterns under all eight bases.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
  localparam int unsigned N   = 8;
  localparam int unsigned LW  = $clog2(N);
  localparam int unsigned PW  = LW + 1;
  localparam int unsigned DW  = 8;
  localparam int unsigned VBW = DW - LW;
  localparam int unsigned CASCADE_LINE = 2;

  typedef enum logic [1:0] {IW_IDLE, IW_BASE, IW_SECOND, IW_FOURTH} iw_e;

  typedef struct packed {
    logic [N-1:0]   imr;
    logic [N-1:0]   isr;
    logic [LW-1:0]  base;
    logic [VBW-1:0] vbase;
    logic           rsel;
    logic           poll;
    logic           smm;
    logic           aeoi;
    logic           rot_aeoi;
    logic           sfnm;
    logic           init4;
    iw_e            iw;
  } ctl_t;

  function automatic logic [LW-1:0] line_of(logic [LW-1:0] prio, logic [LW-1:0] base);
    return prio + base;
  endfunction
endpackage

// File: rtl/rpic_prio.sv
module rpic_prio
  import rpic_pkg::*;
(
  input  logic [N-1:0]  vec_i,
  input  logic [LW-1:0] base_i,
  output logic [PW-1:0] prio_o
);
  logic [N-1:0] rot;

  for (genvar i = 0; i < N; i++) begin : g_rot
    localparam logic [LW-1:0] IDX = LW'(i);
    assign rot[i] = vec_i[IDX + base_i];
  end

  // prio_o == N means empty
  always_comb begin
    prio_o = PW'(N);
    for (int i = N - 1; i >= 0; i--) begin
      if (rot[i]) prio_o = PW'(i);
    end
  end
endmodule

// File: rtl/rpic_req.sv
module rpic_req
  import rpic_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         init_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] irr_o
);
  logic [N-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else if (init_i) begin
      prev_q <= '0;
      irr_o  <= '0;
    end else begin
      prev_q <= irq_i;
      irr_o  <= (level_i & irq_i) |
                (~level_i & ((irr_o & ~clr_i) | (irq_i & ~prev_q)));
    end
  end
endmodule

// File: rtl/rpic_top.sv
module rpic_top
  import rpic_pkg::*;
#(
  parameter bit IS_MASTER = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  irq_i,
  input  logic [N-1:0]  trig_level_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic          addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          ack_i,
  output logic          int_o,
  output logic          ack_valid_o,
  output logic [LW-1:0] ack_line_o,
  output logic [DW-1:0] ack_vec_o
);
  localparam logic [N-1:0] CAS_BIT = {{(N-1){1'b0}}, 1'b1} << CASCADE_LINE;

  ctl_t st_q, st_n;
  logic [N-1:0]  irr_q, irr_clr, srv_cmp;
  logic [PW-1:0] req_prio, srv_prio, eoi_prio;
  logic [LW-1:0] win_line, eoi_line;
  logic          win, eoi_found;
  logic          wr0, wr1, is_init, is_ocw3, is_ocw2, poll_rd;
  logic [2:0]    cmd;
  logic [DW-1:0] rd_val;

  assign wr0     = wr_i && !addr_i;
  assign wr1     = wr_i && addr_i;
  assign is_init = wr0 && wdata_i[4];
  assign is_ocw3 = wr0 && !wdata_i[4] && wdata_i[3];
  assign is_ocw2 = wr0 && !wdata_i[4] && !wdata_i[3];
  assign cmd     = wdata_i[7:5];
  assign poll_rd = rd_i && st_q.poll;

  rpic_req u_req (
    .clk_i, .rst_ni, .init_i(is_init), .level_i(trig_level_i),
    .irq_i, .clr_i(irr_clr), .irr_o(irr_q)
  );

  assign srv_cmp = st_q.isr & ~(st_q.smm ? st_q.imr : '0)
                 & ~((IS_MASTER && st_q.sfnm) ? CAS_BIT : '0);

  rpic_prio u_req_pr (.vec_i(irr_q & ~st_q.imr), .base_i(st_q.base), .prio_o(req_prio));
  rpic_prio u_srv_pr (.vec_i(srv_cmp),           .base_i(st_q.base), .prio_o(srv_prio));
  rpic_prio u_eoi_pr (.vec_i(st_q.isr),          .base_i(st_q.base), .prio_o(eoi_prio));

  assign win       = (req_prio < srv_prio);
  assign win_line  = line_of(req_prio[LW-1:0], st_q.base);
  assign eoi_found = !eoi_prio[LW];
  assign eoi_line  = line_of(eoi_prio[LW-1:0], st_q.base);
  assign int_o     = win;

  always_comb begin
    st_n    = st_q;
    irr_clr = '0;
    if (ack_i && win) begin
      if (st_q.aeoi) begin
        if (st_q.rot_aeoi) st_n.base = win_line + LW'(1);
      end else begin
        st_n.isr[win_line] = 1'b1;
      end
      irr_clr[win_line] = !trig_level_i[win_line];
    end
    if (poll_rd) begin
      st_n.poll = 1'b0;
      if (win) begin
        st_n.isr[win_line] = 1'b0;
        irr_clr[win_line]  = 1'b1;
      end
    end
    if (is_ocw2) begin
      case (cmd)
        3'd0, 3'd4: st_n.rot_aeoi = cmd[2];
        3'd1, 3'd5: if (eoi_found) begin
          st_n.isr[eoi_line] = 1'b0;
          if (cmd[2]) st_n.base = eoi_line + LW'(1);
        end
        3'd3: st_n.isr[wdata_i[LW-1:0]] = 1'b0;
        3'd6: st_n.base = wdata_i[LW-1:0] + LW'(1);
        3'd7: begin
          st_n.isr[wdata_i[LW-1:0]] = 1'b0;
          st_n.base = wdata_i[LW-1:0] + LW'(1);
        end
        default: ;
      endcase
    end
    if (is_ocw3) begin
      if (wdata_i[2]) st_n.poll = 1'b1;
      if (wdata_i[1]) st_n.rsel = wdata_i[0];
      if (wdata_i[6]) st_n.smm  = wdata_i[5];
    end
    if (wr1) begin
      case (st_q.iw)
        IW_IDLE:   st_n.imr = wdata_i;
        IW_BASE: begin
          st_n.vbase = wdata_i[DW-1:LW];
          st_n.iw    = IW_SECOND;
        end
        IW_SECOND: st_n.iw = st_q.init4 ? IW_FOURTH : IW_IDLE;
        default: begin
          st_n.sfnm = wdata_i[4];
          st_n.aeoi = wdata_i[1];
          st_n.iw   = IW_IDLE;
        end
      endcase
    end
    if (is_init) begin
      st_n       = '0;
      st_n.iw    = IW_BASE;
      st_n.init4 = wdata_i[0];
    end
  end

  always_comb begin
    if (st_q.poll)   rd_val = win ? DW'(win_line) : DW'(N - 1);
    else if (addr_i) rd_val = st_q.imr;
    else if (st_q.rsel) rd_val = st_q.isr;
    else             rd_val = irr_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= '0;
      rdata_o     <= '0;
      ack_valid_o <= 1'b0;
      ack_line_o  <= '0;
      ack_vec_o   <= '0;
    end else begin
      st_q <= st_n;
      if (rd_i) rdata_o <= rd_val;
      ack_valid_o <= ack_i && win;
      if (ack_i) begin
        ack_line_o <= win ? win_line : LW'(N - 1);
        ack_vec_o  <= {st_q.vbase, (win ? win_line : LW'(N - 1))};
      end
    end
  end
endmodule

// File: rtl/rpic_chk.sv
module rpic_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         wr_i,
  input logic         rd_i,
  input logic         addr_i,
  input logic [7:0]   wdata_i,
  input logic         ack_i,
  input logic         int_o,
  input logic         ack_valid_o,
  input logic [N-1:0] irr,
  input logic [N-1:0] imr,
  input logic [N-1:0] isr,
  input logic         poll,
  input logic         aeoi
);
  a_r3_masked_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (imr == '1) |-> !int_o);

  a_r4_int_needs_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> ((irr & ~imr) != '0));

  a_r6_valid_after_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_valid_o |-> $past(ack_i));

  a_r7_aeoi_keeps_isr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && aeoi && !wr_i && !rd_i) |=> $stable(isr));

  a_r8_init_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i && wdata_i[4]) |=> (imr == '0 && isr == '0 && irr == '0 && !int_o));

  a_r12_poll_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && poll && !wr_i) |=> !poll);
endmodule

bind rpic_top rpic_chk #(.N(rpic_pkg::N)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .rd_i(rd_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .ack_i(ack_i), .int_o(int_o), .ack_valid_o(ack_valid_o),
  .irr(irr_q), .imr(st_q.imr), .isr(st_q.isr), .poll(st_q.poll), .aeoi(st_q.aeoi)
);

// File: tb/tb_rpic_top.sv
`timescale 1ns/1ps
module tb_rpic_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic [7:0] irq = '0, trig = '0, wdata = '0;
  logic wr = 1'b0, rd = 1'b0, addr = 1'b0, ack = 1'b0;
  logic [7:0] rdata, ack_vec;
  logic [2:0] ack_line;
  logic int_o, ack_valid;
  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rpic_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .irq_i(irq), .trig_level_i(trig),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ack_i(ack), .int_o(int_o), .ack_valid_o(ack_valid),
    .ack_line_o(ack_line), .ack_vec_o(ack_vec)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_ni = 1'b0; irq = '0; trig = '0; wr = 0; rd = 0; ack = 0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr_reg(logic a, logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [7:0] d);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic raise(int l);
    irq[l] = 1'b1;
    @(negedge clk);
  endtask

  task automatic drop(int l);
    irq[l] = 1'b0;
    @(negedge clk);
  endtask

  task automatic init4(logic [7:0] vb, logic [7:0] w4);
    wr_reg(0, 8'h11); wr_reg(1, vb); wr_reg(1, 8'h00); wr_reg(1, w4);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    // reset state and spurious acknowledge (R6)
    reset_dut();
    chk("R4 reset int_o", {7'd0, int_o}, 8'h00);
    rd_reg(1, v); chk("R3 reset mask", v, 8'h00);
    rd_reg(0, v); chk("R9 reset irr", v, 8'h00);
    do_ack();
    chk("R6 spurious valid", {7'd0, ack_valid}, 8'h00);
    chk("R6 spurious line", {5'd0, ack_line}, 8'h07);

    // R1 edge capture, R6 acknowledge, R10 non-specific EOI
    reset_dut(); init4(8'h20, 8'h00);
    raise(3); chk("R1 edge sets int", {7'd0, int_o}, 8'h01);
    do_ack();
    chk("R6 valid", {7'd0, ack_valid}, 8'h01);
    chk("R6 line", {5'd0, ack_line}, 8'h03);
    chk("R6 vector", ack_vec, 8'h23);
    chk("R4 served line blocks", {7'd0, int_o}, 8'h00);
    wr_reg(0, 8'h20);
    wr_reg(0, 8'h0B); rd_reg(0, v); chk("R10 eoi clears isr", v, 8'h00);
    chk("R1 held high no retrigger", {7'd0, int_o}, 8'h00);
    drop(3); raise(3); chk("R1 new edge", {7'd0, int_o}, 8'h01);

    // R2 level capture
    reset_dut(); trig = 8'h20;
    raise(5); chk("R2 level high", {7'd0, int_o}, 8'h01);
    drop(5);  chk("R2 level low", {7'd0, int_o}, 8'h00);
    raise(5); do_ack();
    chk("R2 ack line", {5'd0, ack_line}, 8'h05);
    chk("R4 equal rank no int", {7'd0, int_o}, 8'h00);
    wr_reg(0, 8'h0A); rd_reg(0, v); chk("R2 irr kept", v, 8'h20);
    wr_reg(0, 8'h0B); rd_reg(0, v); chk("R9 isr read", v, 8'h20);

    // R3 mask
    reset_dut(); wr_reg(1, 8'h08);
    raise(3); chk("R3 masked silent", {7'd0, int_o}, 8'h00);
    rd_reg(1, v); chk("R3 mask readback", v, 8'h08);
    wr_reg(1, 8'h00); chk("R3 unmask", {7'd0, int_o}, 8'h01);

    // R4 nesting, R10 rotating non-specific EOI
    reset_dut();
    raise(2); raise(6); do_ack();
    chk("R4 first line", {5'd0, ack_line}, 8'h02);
    chk("R4 lower rank held", {7'd0, int_o}, 8'h00);
    raise(1); chk("R4 higher rank nests", {7'd0, int_o}, 8'h01);
    do_ack(); chk("R4 nested line", {5'd0, ack_line}, 8'h01);
    wr_reg(0, 8'hA0);
    wr_reg(0, 8'h0B); rd_reg(0, v); chk("R10 rotate eoi isr", v, 8'h04);
    chk("R10 base moved", {7'd0, int_o}, 8'h00);
    wr_reg(0, 8'h20); chk("R10 eoi line2", {7'd0, int_o}, 8'h01);
    do_ack(); chk("R10 line6 served", {5'd0, ack_line}, 8'h06);

    // R11 specific EOI and set-base
    reset_dut();
    raise(4); do_ack();
    wr_reg(0, 8'h0B);
    wr_reg(0, 8'h63); rd_reg(0, v); chk("R11 specific other", v, 8'h10);
    wr_reg(0, 8'h64); rd_reg(0, v); chk("R11 specific hit", v, 8'h00);
    raise(0); raise(6);
    wr_reg(0, 8'hE4); do_ack();
    chk("R11 code7 base", {5'd0, ack_line}, 8'h06);
    reset_dut();
    raise(1); raise(3); wr_reg(0, 8'hC2); do_ack();
    chk("R11 code6 base", {5'd0, ack_line}, 8'h03);

    // R7 auto-EOI with rotation
    reset_dut(); init4(8'h00, 8'h02);
    raise(4); do_ack();
    chk("R7 aeoi line", {5'd0, ack_line}, 8'h04);
    wr_reg(0, 8'h0B); rd_reg(0, v); chk("R7 isr untouched", v, 8'h00);
    wr_reg(0, 8'h80);
    raise(5); do_ack();
    raise(1); raise(7); do_ack();
    chk("R7 rotated base", {5'd0, ack_line}, 8'h07);

    // R5 nested cascade mode
    reset_dut(); init4(8'h00, 8'h10);
    raise(2); do_ack(); raise(4);
    chk("R5 line2 ignored", {7'd0, int_o}, 8'h01);
    reset_dut(); init4(8'h00, 8'h00);
    raise(2); do_ack(); raise(4);
    chk("R5 off line2 counts", {7'd0, int_o}, 8'h00);

    // R8 start-up sequences
    reset_dut();
    wr_reg(1, 8'hFF); wr_reg(0, 8'h10);
    rd_reg(1, v); chk("R8 init clears mask", v, 8'h00);
    wr_reg(1, 8'h4F); wr_reg(1, 8'h00); wr_reg(1, 8'hF0);
    rd_reg(1, v); chk("R8 three-word then mask", v, 8'hF0);
    wr_reg(1, 8'h00);
    raise(1); chk("R8 pending", {7'd0, int_o}, 8'h01);
    wr_reg(0, 8'h11); chk("R8 init drops int", {7'd0, int_o}, 8'h00);
    wr_reg(1, 8'h30); wr_reg(1, 8'h00); wr_reg(1, 8'h02);
    rd_reg(1, v); chk("R8 fourth word not mask", v, 8'h00);
    do_ack(); chk("R8 vector base", ack_vec, 8'h31);
    wr_reg(0, 8'h0B); rd_reg(0, v); chk("R8 fourth word aeoi", v, 8'h00);

    // R12 poll
    reset_dut();
    wr_reg(0, 8'h0C); rd_reg(0, v); chk("R12 poll empty", v, 8'h07);
    raise(5); wr_reg(0, 8'h0C); rd_reg(0, v); chk("R12 poll line", v, 8'h05);
    wr_reg(0, 8'h0A); rd_reg(0, v); chk("R12 poll cleared irr", v, 8'h00);
    drop(5); raise(3); rd_reg(0, v); chk("R12 poll disarmed", v, 8'h08);

    // R13 special mask
    reset_dut();
    raise(2); do_ack(); wr_reg(1, 8'h04); raise(5);
    chk("R13 off", {7'd0, int_o}, 8'h00);
    wr_reg(0, 8'h68); chk("R13 on", {7'd0, int_o}, 8'h01);
    wr_reg(0, 8'h48); chk("R13 off again", {7'd0, int_o}, 8'h00);

    // R4 sweep: every request pattern under every base, observed by poll
    reset_dut(); trig = 8'hFF;
    for (int b = 0; b < 8; b++) begin
      wr_reg(0, 8'hC0 | 8'((b + 7) % 8));
      for (int p = 1; p < 256; p++) begin
        int e;
        irq = 8'(p);
        @(negedge clk);
        e = -1;
        for (int k = 7; k >= 0; k--) if (p[(b + k) % 8]) e = (b + k) % 8;
        chk("R4 sweep int", {7'd0, int_o}, 8'h01);
        wr_reg(0, 8'h0C); rd_reg(0, v);
        chk("R4 sweep winner", v, 8'(e));
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule